// File: doc/BRIEF.md
# Side-Effect-Safe Wide-to-Narrow Register Bridge

This block joins a 64-bit memory-mapped slave port, as driven by a host bridge that always issues 64-bit-wide cycles, to a 32-bit register file whose registers are not prefetchable. It looks at the eight upstream byte enables and turns each upstream cycle into downstream accesses only for the 32-bit halves that carry at least one enabled byte. A lone 32-bit host access therefore reaches exactly one register. A read with side effects, such as a clear-on-read status word, never touches its neighbour.

The 32-bit register map keeps its layout. The downstream word address is the upstream 64-bit address shifted left by one. Its low bit is 1 when the upper half is addressed. Read data returns on the 64-bit lane of the half that was read. When both halves are enabled, the lower word is accessed first and the upper word second, and the upstream cycle waits for both. Back-pressure from the register side stretches the upstream cycle.

Top module: `wide_to_narrow_reg_bridge`

## Requirements
- R1: While reset is held and after its release with no request, `up_waitreq`, `dn_read` and `dn_write` are all low.
- R2: When only `up_be[3:0]` has enabled bytes, exactly one downstream access is made, at word address `{up_addr,1'b0}`, with `dn_be = up_be[3:0]`.
- R3: When only `up_be[7:4]` has enabled bytes, exactly one downstream access is made, at word address `{up_addr,1'b1}`, with `dn_be = up_be[7:4]`.
- R4: A 32-bit half whose four byte enables are all zero is never accessed downstream, so the register next to the addressed one is never read or written.
- R5: When both halves have enabled bytes, two downstream accesses are made, the lower word first and then the upper word.
- R6: Read data from the lower word appears on `up_rdata[31:0]` and from the upper word on `up_rdata[63:32]`. A half that was not read returns zero.
- R7: On a write, `up_wdata[31:0]` is forwarded for the lower word and `up_wdata[63:32]` for the upper word. Only the enabled bytes of the register change.
- R8: A request with all eight byte enables zero completes without any downstream access.
- R9: While `dn_waitreq` is high, the downstream strobe, address, byte enables and write data stay stable. Each such cycle extends the upstream cycle by one clock.
- R10: With n downstream accesses (0, 1 or 2) and s stalled downstream cycles, `up_waitreq` drops in the cycle after the (1+n+s)-th rising edge following the request. The request is accepted on the edge after that.
- R11: `dn_read` and `dn_write` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_addr | input | UP_AW | 64-bit word address from the host side |
| up_read | input | 1 | Upstream read request, held until accepted |
| up_write | input | 1 | Upstream write request, held until accepted |
| up_be | input | 8 | Upstream byte enables |
| up_wdata | input | 64 | Upstream write data |
| up_rdata | output | 64 | Upstream read data, valid when a read is accepted |
| up_waitreq | output | 1 | High while the upstream request must be held |
| dn_addr | output | UP_AW+1 | 32-bit register word address |
| dn_read | output | 1 | Downstream read strobe |
| dn_write | output | 1 | Downstream write strobe |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid when a read strobe is not stalled |
| dn_waitreq | input | 1 | Downstream stall |

## Verification
Counting from the rising edge that first sees an upstream request, the downstream strobe for the first enabled half appears one cycle later. Each half then occupies one cycle plus one cycle for every stalled edge. `up_waitreq` drops in the cycle that follows, so an empty request is done two edges after it is presented, one half after three edges and two halves after four, plus any stalls. The bench drives requests at the falling edge and samples `up_waitreq` and `up_rdata` half a period later. It counts the rising edges up to acceptance and the stalled edges seen by its register model, and compares the total against that formula. The access log and the per-register read counters are checked only after the transaction has been accepted.

// File: rtl/wide_to_narrow_reg_bridge.sv
module wide_to_narrow_reg_bridge #(
  parameter int UP_AW = 4,
  parameter int NW    = 32,
  localparam int NB   = NW / 8,
  localparam int WW   = 2 * NW,
  localparam int WB   = 2 * NB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UP_AW-1:0] up_addr,
  input  logic             up_read,
  input  logic             up_write,
  input  logic [WB-1:0]    up_be,
  input  logic [WW-1:0]    up_wdata,
  output logic [WW-1:0]    up_rdata,
  output logic             up_waitreq,
  output logic [UP_AW:0]   dn_addr,
  output logic             dn_read,
  output logic             dn_write,
  output logic [NB-1:0]    dn_be,
  output logic [NW-1:0]    dn_wdata,
  input  logic [NW-1:0]    dn_rdata,
  input  logic             dn_waitreq
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_DONE} state_t;

  state_t        st;
  logic [NW-1:0] lo_q, hi_q;

  wire req     = up_read | up_write;
  wire need_lo = |up_be[NB-1:0];
  wire need_hi = |up_be[WB-1:NB];
  wire on_hi   = (st == S_HI);
  wire busy    = (st == S_LO) | on_hi;

  assign dn_read    = busy & up_read;
  assign dn_write   = busy & up_write & ~up_read;
  assign dn_addr    = {up_addr, on_hi};
  assign dn_be      = on_hi ? up_be[WB-1:NB] : up_be[NB-1:0];
  assign dn_wdata   = on_hi ? up_wdata[WW-1:NW] : up_wdata[NW-1:0];
  assign up_waitreq = req & (st != S_DONE);
  assign up_rdata   = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          lo_q <= '0;
          hi_q <= '0;
          st   <= need_lo ? S_LO : (need_hi ? S_HI : S_DONE);
        end
        S_LO: if (!dn_waitreq) begin
          if (up_read) lo_q <= dn_rdata;
          st <= need_hi ? S_HI : S_DONE;
        end
        S_HI: if (!dn_waitreq) begin
          if (up_read) hi_q <= dn_rdata;
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module wide_to_narrow_reg_bridge_checker #(
  parameter int UP_AW = 4,
  parameter int NW    = 32,
  localparam int NB   = NW / 8,
  localparam int WW   = 2 * NW,
  localparam int WB   = 2 * NB
) (
  input logic             clk,
  input logic             rst_n,
  input logic [UP_AW-1:0] up_addr,
  input logic             up_read,
  input logic [WB-1:0]    up_be,
  input logic [WW-1:0]    up_rdata,
  input logic             up_waitreq,
  input logic [UP_AW:0]   dn_addr,
  input logic             dn_read,
  input logic             dn_write,
  input logic [NB-1:0]    dn_be,
  input logic [NW-1:0]    dn_wdata,
  input logic             dn_waitreq
);

  wire strobe = dn_read | dn_write;

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_read && dn_write));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dn_waitreq) |=> (dn_read == $past(dn_read)) && (dn_write == $past(dn_write))
      && $stable(dn_addr) && $stable(dn_be) && $stable(dn_wdata));

  assert_no_empty_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (dn_be != '0));

  assert_lower_only_if_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !dn_addr[0]) |-> (|up_be[NB-1:0]) && (dn_addr[UP_AW:1] == up_addr));

  assert_upper_only_if_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && dn_addr[0]) |-> (|up_be[WB-1:NB]) && (dn_addr[UP_AW:1] == up_addr));

  assert_unused_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_read && !up_waitreq) |->
      ((|up_be[NB-1:0]) || up_rdata[NW-1:0] == '0) &&
      ((|up_be[WB-1:NB]) || up_rdata[WW-1:NW] == '0));

endmodule

bind wide_to_narrow_reg_bridge wide_to_narrow_reg_bridge_checker #(.UP_AW(UP_AW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_addr(up_addr), .up_read(up_read), .up_be(up_be),
  .up_rdata(up_rdata), .up_waitreq(up_waitreq), .dn_addr(dn_addr), .dn_read(dn_read),
  .dn_write(dn_write), .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_waitreq(dn_waitreq)
);

// File: tb/wide_to_narrow_reg_bridge_bench.sv
`timescale 1ns/1ps
module wide_to_narrow_reg_bridge_bench;
  localparam int AW = 4;
  localparam int NREG = 2 ** (AW + 1);

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] up_addr = '0;
  logic          up_read = 0, up_write = 0;
  logic [7:0]    up_be = '0;
  logic [63:0]   up_wdata = '0;
  logic [63:0]   up_rdata;
  logic          up_waitreq;
  logic [AW:0]   dn_addr;
  logic          dn_read, dn_write;
  logic [3:0]    dn_be;
  logic [31:0]   dn_wdata, dn_rdata;
  logic          dn_waitreq = 0;

  wide_to_narrow_reg_bridge #(.UP_AW(AW), .NW(32)) u_wide_to_narrow_reg_bridge (
    .clk(clk), .rst_n(rst_n), .up_addr(up_addr), .up_read(up_read), .up_write(up_write),
    .up_be(up_be), .up_wdata(up_wdata), .up_rdata(up_rdata), .up_waitreq(up_waitreq),
    .dn_addr(dn_addr), .dn_read(dn_read), .dn_write(dn_write), .dn_be(dn_be),
    .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_waitreq(dn_waitreq));

  always #4 clk = ~clk;

  logic [31:0] mem [NREG];
  int          rdcnt [NREG];
  logic [AW:0] log_addr [4];
  logic [3:0]  log_be [4];
  logic        log_wr [4];
  logic [31:0] log_wd [4];
  int          nlog, stalls;
  int          n_chk = 0, n_fail = 0;
  bit          stall_on = 0;

  assign dn_rdata = mem[dn_addr];

  always @(posedge clk) begin
    if ((dn_read || dn_write) && dn_waitreq) stalls++;
    else if (dn_read || dn_write) begin
      if (nlog < 4) begin
        log_addr[nlog] = dn_addr; log_be[nlog] = dn_be;
        log_wr[nlog] = dn_write;  log_wd[nlog] = dn_wdata;
      end
      nlog++;
      if (dn_read) rdcnt[dn_addr]++;
      if (dn_write)
        for (int b = 0; b < 4; b++) if (dn_be[b]) mem[dn_addr][8*b +: 8] = dn_wdata[8*b +: 8];
    end
  end

  always @(negedge clk) dn_waitreq <= stall_on ? ($urandom % 3 == 0) : 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic xact(bit wr, logic [AW-1:0] a, logic [7:0] be, logic [63:0] wd);
    bit lo = |be[3:0], hi = |be[7:4];
    int n = int'(lo) + int'(hi);
    int edges = 0;
    logic [AW:0] la = {a, 1'b0}, ha = {a, 1'b1};
    logic [31:0] exp_lo = merge(mem[la], wd[31:0], be[3:0]);
    logic [31:0] exp_hi = merge(mem[ha], wd[63:32], be[7:4]);
    logic [63:0] exp_rd = {hi ? mem[ha] : 32'h0, lo ? mem[la] : 32'h0};
    int rl0 = rdcnt[la], rh0 = rdcnt[ha];
    logic [63:0] got;
    int k = 0;
    @(negedge clk);
    nlog = 0; stalls = 0;
    up_addr = a; up_be = be; up_wdata = wd; up_read = !wr; up_write = wr;
    forever begin
      #1;
      if (!up_waitreq) begin
        got = up_rdata;
        @(posedge clk); edges++;
        break;
      end
      @(posedge clk); edges++;
      @(negedge clk);
    end
    @(negedge clk);
    up_read = 0; up_write = 0;
    chk(n == 0 ? "R8 access count" : "R4 access count", 64'(nlog), 64'(n));
    chk("R10 accept edge", 64'(edges), 64'(2 + n + stalls));
    if (lo) begin
      chk("R2 lower addr", 64'(log_addr[k]), 64'(la));
      chk("R2 lower be", 64'(log_be[k]), 64'(be[3:0]));
      if (wr) chk("R7 lower wdata", 64'(log_wd[k]), 64'(wd[31:0]));
      k++;
    end
    if (hi) begin
      chk(lo ? "R5 second is upper" : "R3 upper addr", 64'(log_addr[k]), 64'(ha));
      chk("R3 upper be", 64'(log_be[k]), 64'(be[7:4]));
      if (wr) chk("R7 upper wdata", 64'(log_wd[k]), 64'(wd[63:32]));
    end
    if (wr) begin
      chk("R7 lower word", 64'(mem[la]), 64'(exp_lo));
      chk("R7 upper word", 64'(mem[ha]), 64'(exp_hi));
    end else begin
      chk("R6 read data", got, exp_rd);
      chk("R4 lower reads", 64'(rdcnt[la] - rl0), 64'(lo));
      chk("R4 upper reads", 64'(rdcnt[ha] - rh0), 64'(hi));
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NREG; i++) begin mem[i] = $urandom; rdcnt[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 waitreq in reset", 64'(up_waitreq), 0);
    chk("R1 strobes in reset", 64'({dn_read, dn_write}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", 64'({up_waitreq, dn_read, dn_write}), 0);

    xact(0, 4'd2, 8'h0F, '0);
    xact(0, 4'd2, 8'hF0, '0);
    xact(0, 4'd5, 8'h00, '0);
    xact(1, 4'd5, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    xact(0, 4'd7, 8'hFF, '0);
    xact(1, 4'd3, 8'h30, 64'hAAAA_BBBB_CCCC_DDDD);
    xact(1, 4'd3, 8'h81, 64'h1122_3344_5566_7788);
    xact(0, 4'd3, 8'hFF, '0);
    xact(1, 4'd15, 8'hFF, 64'hDEAD_BEEF_0BAD_F00D);

    stall_on = 1;
    xact(0, 4'd1, 8'hFF, '0);
    xact(1, 4'd1, 8'h0F, 64'h0123_4567_89AB_CDEF);

    for (int i = 0; i < 300; i++) begin
      logic [7:0] be;
      case ($urandom % 5)
        0: be = 8'h00;
        1: be = {4'h0, 4'($urandom % 15 + 1)};
        2: be = {4'($urandom % 15 + 1), 4'h0};
        3: be = 8'hFF;
        default: be = 8'($urandom);
      endcase
      stall_on = ($urandom % 2) == 1;
      xact(($urandom % 2) == 1, AW'($urandom), be, {$urandom, $urandom});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule